// File: doc/BRIEF.md
# Accumulator Register-Operation Unit

This block carries out the accumulator-only instructions of a small 16-bit accumulator machine. It holds the 16-bit accumulator and the 1-bit extension flag, and during the execute step of an instruction whose top nibble reads `0111` it applies every operation whose select bit is set in the low twelve bits of the instruction word. Each select bit names one operation: clearing or inverting the accumulator or the flag, rotating the accumulator through the flag in either direction, incrementing the accumulator, four conditional skip tests, and a stop.

The surrounding sequencer supplies the instruction word and a strobe for the execute step. It takes three things back in that same cycle: a skip request that tells it to advance the program counter by one more word, a pulse that sends its step counter back to zero, and a sticky stopped flag. A plain load port lets the rest of the datapath write the accumulator and the flag whenever no operation runs.

Top module: `acc_regop_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `ac_q`, `e_q` and `halted` all become 0.
- R2: An operation runs only in a cycle where `step_t3` is 1, `ir[15:12]` is `4'b0111` and `halted` is 0. In any other cycle `skip_req` and `sc_clr` are 0, and `ac_q` and `e_q` change only through the load port.
- R3: `ir[11]` clears the accumulator. `ir[10]` clears the flag.
- R4: `ir[9]` inverts every accumulator bit. `ir[8]` inverts the flag.
- R5: `ir[7]` rotates right through the flag: the accumulator becomes `{e, ac[15:1]}` and the flag becomes `ac[0]`. `ir[6]` rotates left: the accumulator becomes `{ac[14:0], e}` and the flag becomes `ac[15]`.
- R6: `ir[5]` adds one to the accumulator modulo 2^16 and leaves the flag as it is.
- R7: `skip_req` is combinational in the operation cycle. It is the OR of these tests, each made on the accumulator and flag as they stand before the edge: `ir[4]` and `ac[15]==0`; `ir[3]` and `ac[15]==1`; `ir[2]` and `ac==0`; `ir[1]` and `e==0`.
- R8: `ir[0]` sets `halted` at the edge that ends the operation cycle. `halted` stays 1 until reset, and while it is 1 no operation runs.
- R9: `sc_clr` is 1 throughout every cycle in which an operation runs.
- R10: When several operation bits are set together, they act as a chain in this order, each step on the result of the one before: clear accumulator, clear flag, invert accumulator, invert flag, rotate right, rotate left, increment.
- R11: When `wr_en` is 1 and no operation runs, `ac_q` takes `wr_ac` and `e_q` takes `wr_e` at the next edge. When an operation runs in the same cycle, the operation wins and the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_t3 | input | 1 | Execute-step strobe from the sequencer |
| ir | input | 16 | Current instruction word |
| wr_en | input | 1 | Load strobe for accumulator and flag |
| wr_ac | input | 16 | Accumulator load value |
| wr_e | input | 1 | Flag load value |
| ac_q | output | 16 | Accumulator |
| e_q | output | 1 | Extension flag |
| skip_req | output | 1 | Advance the program counter by one extra word |
| halted | output | 1 | Sticky stop flag |
| sc_clr | output | 1 | Send the step counter back to zero |

## Verification
The assertions take the instruction word and the execute strobe to be stable across each clock edge. They also take a pure rotate or a pure increment to be present only in an operation cycle, so that the value one edge later can be predicted from the accumulator alone. The bench changes its inputs only on the falling clock edge and holds `ir` steady for the whole cycle in which `step_t3` is high. Every load is made in a cycle of its own, except for the one directed test that raises the load strobe and an operation together to check which one wins.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int WORD_W  = 16;
    localparam int OPC_W   = 4;
    localparam int SEL_W   = WORD_W - OPC_W;
    localparam int STAGE_N = 7;

    localparam logic [OPC_W-1:0] OPC_REGOP = 4'b0111;

    // select-bit positions inside the low field
    localparam int SB_CLR_AC = 11;
    localparam int SB_CLR_E  = 10;
    localparam int SB_INV_AC = 9;
    localparam int SB_INV_E  = 8;
    localparam int SB_ROT_R  = 7;
    localparam int SB_ROT_L  = 6;
    localparam int SB_INC    = 5;
    localparam int SB_T_POS  = 4;
    localparam int SB_T_NEG  = 3;
    localparam int SB_T_ZERO = 2;
    localparam int SB_T_EZ   = 1;
    localparam int SB_STOP   = 0;

    typedef struct packed {
        logic clr_ac;
        logic clr_e;
        logic inv_ac;
        logic inv_e;
        logic rot_r;
        logic rot_l;
        logic inc;
        logic t_pos;
        logic t_neg;
        logic t_zero;
        logic t_ez;
        logic stop;
    } regop_t;

    typedef struct packed {
        logic [WORD_W-1:0] ac;
        logic              e;
    } acc_state_t;

    // stage enables, index 0 acts first
    function automatic logic [STAGE_N-1:0] stage_mask(regop_t o);
        return {o.inc, o.rot_l, o.rot_r, o.inv_e, o.inv_ac, o.clr_e, o.clr_ac};
    endfunction

    function automatic acc_state_t apply_stage(int k, acc_state_t s);
        acc_state_t r;
        r = s;
        case (k)
            0: r.ac = '0;
            1: r.e  = 1'b0;
            2: r.ac = ~s.ac;
            3: r.e  = ~s.e;
            4: begin
                r.ac = {s.e, s.ac[WORD_W-1:1]};
                r.e  = s.ac[0];
            end
            5: begin
                r.ac = {s.ac[WORD_W-2:0], s.e};
                r.e  = s.ac[WORD_W-1];
            end
            6: r.ac = s.ac + {{(WORD_W-1){1'b0}}, 1'b1};
            default: r = s;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/regop_decode.sv
module regop_decode
    import acc_pkg::*;
(
    input  logic [WORD_W-1:0] ir,
    input  logic              step_t3,
    input  logic              halted,
    output logic              exec,
    output regop_t            ops
);
    logic [SEL_W-1:0] sel;

    assign exec = step_t3 && !halted && (ir[WORD_W-1 -: OPC_W] == OPC_REGOP);
    assign sel  = exec ? ir[SEL_W-1:0] : '0;

    always_comb begin
        ops        = '0;
        ops.clr_ac = sel[SB_CLR_AC];
        ops.clr_e  = sel[SB_CLR_E];
        ops.inv_ac = sel[SB_INV_AC];
        ops.inv_e  = sel[SB_INV_E];
        ops.rot_r  = sel[SB_ROT_R];
        ops.rot_l  = sel[SB_ROT_L];
        ops.inc    = sel[SB_INC];
        ops.t_pos  = sel[SB_T_POS];
        ops.t_neg  = sel[SB_T_NEG];
        ops.t_zero = sel[SB_T_ZERO];
        ops.t_ez   = sel[SB_T_EZ];
        ops.stop   = sel[SB_STOP];
    end
endmodule

// File: rtl/regop_chain.sv
module regop_chain
    import acc_pkg::*;
(
    input  acc_state_t cur,
    input  regop_t     ops,
    output acc_state_t nxt
);
    acc_state_t       stg [STAGE_N+1];
    logic [STAGE_N-1:0] en;

    assign en     = stage_mask(ops);
    assign stg[0] = cur;

    for (genvar k = 0; k < STAGE_N; k++) begin : g_stage
        assign stg[k+1] = en[k] ? apply_stage(k, stg[k]) : stg[k];
    end

    assign nxt = stg[STAGE_N];
endmodule

// File: rtl/regop_skip.sv
module regop_skip
    import acc_pkg::*;
(
    input  acc_state_t cur,
    input  regop_t     ops,
    output logic       skip
);
    logic sign, zero;

    assign sign = cur.ac[WORD_W-1];
    assign zero = (cur.ac == '0);

    assign skip = (ops.t_pos  && !sign)
               || (ops.t_neg  &&  sign)
               || (ops.t_zero &&  zero)
               || (ops.t_ez   && !cur.e);
endmodule

// File: rtl/acc_regop_unit.sv
module acc_regop_unit
    import acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step_t3,
    input  logic [WORD_W-1:0] ir,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_ac,
    input  logic              wr_e,
    output logic [WORD_W-1:0] ac_q,
    output logic              e_q,
    output logic              skip_req,
    output logic              halted,
    output logic              sc_clr
);
    acc_state_t st_q, st_next;
    regop_t     ops;
    logic       exec;

    regop_decode u_dec (
        .ir      (ir),
        .step_t3 (step_t3),
        .halted  (halted),
        .exec    (exec),
        .ops     (ops)
    );

    regop_chain u_chain (
        .cur (st_q),
        .ops (ops),
        .nxt (st_next)
    );

    regop_skip u_skip (
        .cur  (st_q),
        .ops  (ops),
        .skip (skip_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            halted <= 1'b0;
        end else begin
            if (exec) begin
                st_q <= st_next;
            end else if (wr_en) begin
                st_q <= '{ac: wr_ac, e: wr_e};
            end
            if (ops.stop) begin
                halted <= 1'b1;
            end
        end
    end

    assign sc_clr = exec;
    assign ac_q   = st_q.ac;
    assign e_q    = st_q.e;
endmodule

// File: rtl/acc_regop_chk.sv
module acc_regop_chk (
    input logic        clk,
    input logic        rst,
    input logic        step_t3,
    input logic [15:0] ir,
    input logic        wr_en,
    input logic [15:0] ac_q,
    input logic        e_q,
    input logic        skip_req,
    input logic        halted,
    input logic        sc_clr
);
    logic act;
    assign act = step_t3 && !halted && (ir[15:12] == 4'b0111);

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!act && !wr_en) |=> ($stable(ac_q) && $stable(e_q)));

    a_r9_clr_only_regop: assert property (@(posedge clk) disable iff (rst)
        sc_clr |-> (step_t3 && ir[15:12] == 4'b0111));

    a_r7_skip_in_exec: assert property (@(posedge clk) disable iff (rst)
        skip_req |-> sc_clr);

    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    a_r8_halt_blocks: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!sc_clr && !skip_req));

    a_r6_inc_wraps: assert property (@(posedge clk) disable iff (rst)
        (act && ir[11:0] == 12'h020) |=> (ac_q == 16'($past(ac_q) + 16'd1)));

    a_r5_rot_right: assert property (@(posedge clk) disable iff (rst)
        (act && ir[11:0] == 12'h080) |=>
            (ac_q == {$past(e_q), $past(ac_q[15:1])} && e_q == $past(ac_q[0])));

    a_r3_clear_ac: assert property (@(posedge clk) disable iff (rst)
        (act && ir[11:0] == 12'h800) |=> (ac_q == 16'h0000));
endmodule

bind acc_regop_unit acc_regop_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .step_t3  (step_t3),
    .ir       (ir),
    .wr_en    (wr_en),
    .ac_q     (ac_q),
    .e_q      (e_q),
    .skip_req (skip_req),
    .halted   (halted),
    .sc_clr   (sc_clr)
);

// File: tb/sim_acc_regop_unit.sv
module sim_acc_regop_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_t3 = 1'b0;
    logic [15:0] ir = 16'h0000;
    logic        wr_en = 1'b0;
    logic [15:0] wr_ac = 16'h0000;
    logic        wr_e = 1'b0;
    logic [15:0] ac_q;
    logic        e_q, skip_req, halted, sc_clr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    acc_regop_unit u0 (
        .clk(clk), .rst(rst), .step_t3(step_t3), .ir(ir),
        .wr_en(wr_en), .wr_ac(wr_ac), .wr_e(wr_e),
        .ac_q(ac_q), .e_q(e_q), .skip_req(skip_req),
        .halted(halted), .sc_clr(sc_clr)
    );

    typedef struct packed {
        logic [15:0] ac;
        logic        e;
        logic [11:0] op;
        logic [15:0] xac;
        logic        xe;
        logic        xskip;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{16'h1234, 1'b1, 12'h800, 16'h0000, 1'b1, 1'b0},  // R3
        '{16'h1234, 1'b1, 12'h400, 16'h1234, 1'b0, 1'b0},  // R3
        '{16'h00FF, 1'b0, 12'h200, 16'hFF00, 1'b0, 1'b0},  // R4
        '{16'h00FF, 1'b0, 12'h100, 16'h00FF, 1'b1, 1'b0},  // R4
        '{16'h8001, 1'b0, 12'h080, 16'h4000, 1'b1, 1'b0},  // R5
        '{16'h0001, 1'b1, 12'h080, 16'h8000, 1'b1, 1'b0},  // R5
        '{16'h8001, 1'b0, 12'h040, 16'h0002, 1'b1, 1'b0},  // R5
        '{16'h4000, 1'b1, 12'h040, 16'h8001, 1'b0, 1'b0},  // R5
        '{16'hFFFF, 1'b0, 12'h020, 16'h0000, 1'b0, 1'b0},  // R6
        '{16'h0005, 1'b1, 12'h020, 16'h0006, 1'b1, 1'b0},  // R6
        '{16'h0005, 1'b0, 12'h010, 16'h0005, 1'b0, 1'b1},  // R7
        '{16'h8005, 1'b0, 12'h010, 16'h8005, 1'b0, 1'b0},  // R7
        '{16'h8005, 1'b0, 12'h008, 16'h8005, 1'b0, 1'b1},  // R7
        '{16'h0005, 1'b0, 12'h008, 16'h0005, 1'b0, 1'b0},  // R7
        '{16'h0000, 1'b0, 12'h004, 16'h0000, 1'b0, 1'b1},  // R7
        '{16'h0001, 1'b0, 12'h004, 16'h0001, 1'b0, 1'b0},  // R7
        '{16'h1234, 1'b0, 12'h002, 16'h1234, 1'b0, 1'b1},  // R7
        '{16'h1234, 1'b1, 12'h002, 16'h1234, 1'b1, 1'b0},  // R7
        '{16'h0000, 1'b0, 12'h010, 16'h0000, 1'b0, 1'b1},  // R7 zero counts as positive
        '{16'h1234, 1'b0, 12'hA00, 16'hFFFF, 1'b0, 1'b0},  // R10
        '{16'h1234, 1'b1, 12'h820, 16'h0001, 1'b1, 1'b0},  // R10
        '{16'h8000, 1'b0, 12'h00A, 16'h8000, 1'b0, 1'b1},  // R7 two tests
        '{16'h1234, 1'b1, 12'h440, 16'h2468, 1'b0, 1'b0},  // R10
        '{16'h0001, 1'b0, 12'h180, 16'h8000, 1'b1, 1'b0},  // R10
        '{16'h0000, 1'b0, 12'h804, 16'h0000, 1'b0, 1'b1},  // R7 pre-op test
        '{16'h0005, 1'b0, 12'h804, 16'h0000, 1'b0, 1'b0},  // R7 pre-op test
        '{16'h1234, 1'b1, 12'h0C0, 16'h1234, 1'b1, 1'b0},  // R10 right then left
        '{16'h0000, 1'b1, 12'h402, 16'h0000, 1'b0, 1'b0},  // R7 pre-op flag
        '{16'h7FFF, 1'b0, 12'h220, 16'h8001, 1'b0, 1'b0}   // R10 invert then inc
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] a, input logic e);
        @(negedge clk);
        step_t3 = 1'b0;
        wr_en   = 1'b1;
        wr_ac   = a;
        wr_e    = e;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // drive one execute-step cycle, return comb outputs seen before the edge
    task automatic step(input logic [15:0] word, output logic sk, output logic sc);
        ir      = word;
        step_t3 = 1'b1;
        #1;
        sk = skip_req;
        sc = sc_clr;
        @(negedge clk);
        step_t3 = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic sk, sc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 ac after reset", 32'(ac_q), 32'h0);
        check("R1 e after reset", 32'(e_q), 32'h0);
        check("R1 halted after reset", 32'(halted), 32'h0);

        for (int i = 0; i < NV; i++) begin
            load(VECS[i].ac, VECS[i].e);
            step({4'h7, VECS[i].op}, sk, sc);
            check($sformatf("R9 sc_clr vec %0d", i), 32'(sc), 32'h1);
            check($sformatf("R7 skip vec %0d", i), 32'(sk), 32'(VECS[i].xskip));
            check($sformatf("R3-6,10 ac vec %0d", i), 32'(ac_q), 32'(VECS[i].xac));
            check($sformatf("R5 R10 e vec %0d", i), 32'(e_q), 32'(VECS[i].xe));
        end

        // R2 gating: wrong top nibble, wrong opcode, strobe low
        load(16'h1234, 1'b0);
        step(16'hF020, sk, sc);
        check("R2 io-class word sc_clr", 32'(sc), 32'h0);
        check("R2 io-class word ac", 32'(ac_q), 32'h1234);
        step(16'h6004, sk, sc);
        check("R2 memory-class word skip", 32'(sk), 32'h0);
        check("R2 memory-class word ac", 32'(ac_q), 32'h1234);
        ir = 16'h7820;
        @(negedge clk);
        check("R2 strobe low ac", 32'(ac_q), 32'h1234);
        check("R2 strobe low sc_clr", 32'(sc_clr), 32'h0);

        // R11 load versus operation
        wr_en = 1'b1;
        wr_ac = 16'hAAAA;
        wr_e  = 1'b1;
        step(16'h7020, sk, sc);
        wr_en = 1'b0;
        check("R11 operation wins ac", 32'(ac_q), 32'h1235);
        check("R11 operation wins e", 32'(e_q), 32'h0);
        load(16'h0F0F, 1'b1);
        check("R11 load ac", 32'(ac_q), 32'h0F0F);
        check("R11 load e", 32'(e_q), 32'h1);

        // R8 stop
        step(16'h7001, sk, sc);
        check("R9 sc_clr on stop", 32'(sc), 32'h1);
        check("R8 halted set", 32'(halted), 32'h1);
        check("R8 ac kept on stop", 32'(ac_q), 32'h0F0F);
        step(16'h7800, sk, sc);
        check("R8 no sc_clr while halted", 32'(sc), 32'h0);
        check("R8 no clear while halted", 32'(ac_q), 32'h0F0F);
        step(16'h7010, sk, sc);
        check("R8 no skip while halted", 32'(sk), 32'h0);
        check("R8 halted sticky", 32'(halted), 32'h1);

        // R1 reset from a busy state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 halted cleared", 32'(halted), 32'h0);
        check("R1 ac cleared", 32'(ac_q), 32'h0);
        check("R1 e cleared", 32'(e_q), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule